// File: doc/BRIEF.md
# Soft Interrupt Register Unit

This block holds the software-raised interrupt vector of a CPU core together with the processor interrupt level (PIL) that masks it. Software reaches the vector through three register addresses. The first replaces the whole vector. The second ORs bits into it in one step. The third clears the bits that are set in the write data and leaves the others as they are. A fourth address holds the PIL. Every recognised address is privileged. An unprivileged access is refused with a fault and leaves all state unchanged. An address outside the map is refused with a different fault.

The unit encodes the highest pending level from the vector and compares it with the PIL. From that comparison it drives a level-sensitive interrupt request toward the pipeline. It also watches every vector update. When an update raises the pending level, or when the PIL is written, it emits a one-cycle re-evaluation pulse so that the core looks again at its interrupt inputs.

Access handling is a single-cycle decode into named actions: `ACT_IDLE`, `ACT_RD`, `ACT_WR_DIRECT`, `ACT_WR_SET`, `ACT_WR_CLR`, `ACT_WR_PIL`, `ACT_FLT_PRIV` and `ACT_FLT_ILL`. There are no multi-cycle transitions. Each access is resolved in the cycle it is presented, and its response is registered for the following cycle.

Top module: `softint_unit`

## Requirements
- R1: After reset the vector and the PIL are zero, and `rsp_fault`, `rsp_rdata`, `irq_req` and `reeval_pulse` are all 0.
- R2: A privileged write to address 0 replaces the whole vector. A privileged read of address 0, 1 or 2 returns the vector on `rsp_rdata` in the cycle after the access, and `rsp_rdata` is 0 in any cycle that follows no read.
- R3: A privileged write to address 1 ORs `acc_wdata` into the vector.
- R4: A privileged write to address 2 clears each vector bit that is 1 in `acc_wdata` and keeps every other bit.
- R5: Any access to addresses 0 to 3 with `priv_mode`=0 sets `rsp_fault` to 1 (privileged-opcode) in the next cycle. It changes neither the vector nor the PIL, and `rsp_rdata` stays 0.
- R6: Any access to an address above 3 sets `rsp_fault` to 2 (illegal-instruction) in the next cycle, whatever the mode, and changes no state. `rsp_fault` is 0 after a successful access or an idle cycle.
- R7: The pending level is the index of the highest set bit among vector bits 15 down to 1, and 0 when none of them is set. Bit 0 never contributes. `irq_req` is 1 exactly while that level is strictly greater than the PIL.
- R8: `reeval_pulse` is 1 for exactly the cycle after a vector write (addresses 0, 1 or 2) whose new level is higher than the old level. A vector write that does not raise the level gives no pulse.
- R9: A privileged write to address 3 loads the PIL from `acc_wdata[3:0]` and gives a `reeval_pulse` in the next cycle. A privileged read of address 3 returns the PIL, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register address: 0 direct, 1 set alias, 2 clear alias, 3 PIL |
| acc_wdata | input | 16 | Write data |
| priv_mode | input | 1 | 1 = privileged mode |
| rsp_rdata | output | 16 | Read data, valid in the cycle after a read |
| rsp_fault | output | 2 | 0 none, 1 privileged-opcode, 2 illegal-instruction; cycle after access |
| irq_req | output | 1 | Pending level above the PIL |
| reeval_pulse | output | 1 | One-cycle interrupt re-evaluation request |

## Verification
The bench builds the unit with its default parameters: a 16-bit vector, a 4-bit PIL and a 3-bit address. With these values every level from 0 to 15 is reachable, and so are the PIL extremes 0 and 15 and the four unmapped addresses. This covers the case where bit 0 alone is set and the level equals the PIL. It also covers alias writes that change bits without raising the level, and faulting accesses that carry data which would otherwise alter the state.

// File: rtl/softint_pkg.sv
package softint_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DIRECT = 3'd0;
    localparam logic [ADDR_W-1:0] A_SET    = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLR    = 3'd2;
    localparam logic [ADDR_W-1:0] A_PIL    = 3'd3;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PRIV = 2'd1,
        FLT_ILL  = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_RD,
        ACT_WR_DIRECT,
        ACT_WR_SET,
        ACT_WR_CLR,
        ACT_WR_PIL,
        ACT_FLT_PRIV,
        ACT_FLT_ILL
    } act_e;

endpackage

// File: rtl/softint_decode.sv
module softint_decode
    import softint_pkg::*;
(
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic              priv,
    output act_e              act
);

    always_comb begin
        act = ACT_IDLE;
        if (valid) begin
            if (addr > A_PIL) begin
                act = ACT_FLT_ILL;
            end else if (!priv) begin
                act = ACT_FLT_PRIV;
            end else if (!write) begin
                act = ACT_RD;
            end else begin
                unique case (addr)
                    A_DIRECT: act = ACT_WR_DIRECT;
                    A_SET:    act = ACT_WR_SET;
                    A_CLR:    act = ACT_WR_CLR;
                    A_PIL:    act = ACT_WR_PIL;
                    default:  act = ACT_FLT_ILL;
                endcase
            end
        end
    end

endmodule

// File: rtl/softint_level.sv
module softint_level #(
    parameter int VEC_W = 16,
    localparam int LVL_W = $clog2(VEC_W)
) (
    input  logic [VEC_W-1:0] vec,
    output logic [LVL_W-1:0] lvl
);

    // Per-bit candidates: bit i offers its index when set; bit 0 offers nothing.
    logic [LVL_W-1:0] cand [VEC_W];

    assign cand[0] = '0;

    genvar gi;
    generate
        for (gi = 1; gi < VEC_W; gi++) begin : g_cand
            assign cand[gi] = vec[gi] ? LVL_W'(gi) : cand[gi-1];
        end
    endgenerate

    assign lvl = cand[VEC_W-1];

endmodule

// File: rtl/softint_unit.sv
module softint_unit
    import softint_pkg::*;
#(
    parameter int VEC_W = 16,
    parameter int PIL_W = 4,
    localparam int LVL_W = $clog2(VEC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [VEC_W-1:0]  acc_wdata,
    input  logic              priv_mode,
    output logic [VEC_W-1:0]  rsp_rdata,
    output logic [1:0]        rsp_fault,
    output logic              irq_req,
    output logic              reeval_pulse
);

    act_e             act;
    logic [VEC_W-1:0] vec_q;
    logic [VEC_W-1:0] vec_nxt;
    logic [PIL_W-1:0] pil_q;
    logic [LVL_W-1:0] lvl_cur;
    logic [LVL_W-1:0] lvl_nxt;
    fault_e           fault_q;
    logic [VEC_W-1:0] rdata_q;
    logic             reeval_q;

    softint_decode u_decode (
        .valid (acc_valid),
        .write (acc_write),
        .addr  (acc_addr),
        .priv  (priv_mode),
        .act   (act)
    );

    softint_level #(.VEC_W(VEC_W)) u_lvl_cur (
        .vec (vec_q),
        .lvl (lvl_cur)
    );

    softint_level #(.VEC_W(VEC_W)) u_lvl_nxt (
        .vec (vec_nxt),
        .lvl (lvl_nxt)
    );

    always_comb begin
        unique case (act)
            ACT_WR_DIRECT: vec_nxt = acc_wdata;
            ACT_WR_SET:    vec_nxt = vec_q | acc_wdata;
            ACT_WR_CLR:    vec_nxt = vec_q & ~acc_wdata;
            default:       vec_nxt = vec_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q    <= '0;
            pil_q    <= '0;
            fault_q  <= FLT_NONE;
            rdata_q  <= '0;
            reeval_q <= 1'b0;
        end else begin
            vec_q    <= vec_nxt;
            fault_q  <= FLT_NONE;
            rdata_q  <= '0;
            reeval_q <= 1'b0;
            unique case (act)
                ACT_RD: begin
                    if (acc_addr == A_PIL) rdata_q <= {{(VEC_W-PIL_W){1'b0}}, pil_q};
                    else                   rdata_q <= vec_q;
                end
                ACT_WR_DIRECT, ACT_WR_SET, ACT_WR_CLR: begin
                    reeval_q <= (lvl_nxt > lvl_cur);
                end
                ACT_WR_PIL: begin
                    pil_q    <= acc_wdata[PIL_W-1:0];
                    reeval_q <= 1'b1;
                end
                ACT_FLT_PRIV: fault_q <= FLT_PRIV;
                ACT_FLT_ILL:  fault_q <= FLT_ILL;
                default: ;
            endcase
        end
    end

    assign rsp_rdata    = rdata_q;
    assign rsp_fault    = fault_q;
    assign reeval_pulse = reeval_q;
    assign irq_req      = ({{(PIL_W > LVL_W ? PIL_W - LVL_W : 0){1'b0}}, lvl_cur} > PIL_W'(pil_q));

    p_fault_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 2'd3);

    p_priv_nochange_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !priv_mode && acc_addr <= A_PIL)
        |=> (rsp_fault == 2'd1 && $stable(vec_q) && $stable(pil_q) && rsp_rdata == '0));

    p_illegal_nochange_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr > A_PIL)
        |=> (rsp_fault == 2'd2 && $stable(vec_q) && $stable(pil_q)));

    p_set_keeps_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && priv_mode && acc_addr == A_SET)
        |=> ((vec_q & $past(vec_q)) == $past(vec_q)));

    p_clr_drops_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && priv_mode && acc_addr == A_CLR)
        |=> ((vec_q & $past(acc_wdata)) == '0));

    p_pulse_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reeval_pulse |-> $past(acc_valid && acc_write && priv_mode && acc_addr <= A_PIL));

endmodule

// File: tb/softint_unit_bench.sv
module softint_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic        priv_mode = 1'b0;
    logic [15:0] rsp_rdata;
    logic [1:0]  rsp_fault;
    logic        irq_req;
    logic        reeval_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    int    m_vec = 0;
    int    m_pil = 0;
    int    e_fault = 0;
    int    e_rd = 0;
    int    e_reev = 0;
    int    e_irq = 0;
    string e_tag = "R1";

    always #2.5 clk = ~clk;

    softint_unit u_softint_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_write    (acc_write),
        .acc_addr     (acc_addr),
        .acc_wdata    (acc_wdata),
        .priv_mode    (priv_mode),
        .rsp_rdata    (rsp_rdata),
        .rsp_fault    (rsp_fault),
        .irq_req      (irq_req),
        .reeval_pulse (reeval_pulse)
    );

    function automatic int level_of(int v);
        int l = 0;
        for (int i = 15; i >= 1; i--) begin
            if (((v >> i) & 1) != 0 && l == 0) l = i;
        end
        return l;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(e_tag, "fault",  int'(rsp_fault),    e_fault);
        chk(e_tag, "rdata",  int'(rsp_rdata),    e_rd);
        chk(e_tag, "reeval", int'(reeval_pulse), e_reev);
        chk(e_tag, "irq",    int'(irq_req),      e_irq);
    endtask

    // Compare the outputs of the previous step, then present a new access.
    task automatic step(string tag, bit v, bit w, bit p, int a, int d);
        int old_lvl;
        @(negedge clk);
        compare_all();
        acc_valid = v;
        acc_write = w;
        priv_mode = p;
        acc_addr  = 3'(a);
        acc_wdata = 16'(d);
        old_lvl = level_of(m_vec);
        e_fault = 0;
        e_rd    = 0;
        e_reev  = 0;
        e_tag   = tag;
        if (v) begin
            if (a > 3) e_fault = 2;
            else if (!p) e_fault = 1;
            else if (!w) e_rd = (a == 3) ? m_pil : m_vec;
            else begin
                case (a)
                    0: m_vec = d & 16'hFFFF;
                    1: m_vec = m_vec | (d & 16'hFFFF);
                    2: m_vec = m_vec & ~d & 16'hFFFF;
                    default: begin
                        m_pil  = d & 15;
                        e_reev = 1;
                    end
                endcase
                if (a < 3 && level_of(m_vec) > old_lvl) e_reev = 1;
            end
        end
        e_irq = (level_of(m_vec) > m_pil) ? 1 : 0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state checked at the first step
        step("R1",  0, 0, 1, 0, 0);
        step("R2",  1, 1, 1, 0, 16'h0010);   // level 4, pulse, irq
        step("R2",  1, 0, 1, 0, 0);          // read vector
        step("R9",  1, 1, 1, 3, 16'hFFF6);   // PIL=6, pulse, irq drops
        step("R9",  1, 0, 1, 3, 0);          // read PIL
        step("R3",  1, 1, 1, 1, 16'h0100);   // level 8 > PIL
        step("R8",  1, 1, 1, 1, 16'h0002);   // no level rise: no pulse
        step("R2",  1, 0, 1, 1, 0);          // read through set alias
        step("R4",  1, 1, 1, 2, 16'h0100);   // back to level 4
        step("R4",  1, 0, 1, 2, 0);
        step("R5",  1, 1, 0, 0, 16'hFFFF);
        step("R5",  1, 1, 0, 1, 16'hFFFF);
        step("R5",  1, 1, 0, 3, 16'h0000);
        step("R5",  1, 0, 0, 0, 0);
        step("R5",  1, 0, 1, 0, 0);          // unchanged vector
        step("R5",  1, 0, 1, 3, 0);          // unchanged PIL
        step("R6",  1, 1, 1, 5, 16'hFFFF);
        step("R6",  1, 0, 0, 7, 0);
        step("R6",  1, 0, 1, 4, 0);
        step("R6",  1, 0, 1, 0, 0);          // unchanged after illegal
        step("R7",  1, 1, 1, 3, 0);          // PIL=0
        step("R7",  1, 1, 1, 0, 16'h0001);   // only bit 0: level 0
        step("R7",  1, 1, 1, 3, 15);         // PIL=15
        step("R8",  1, 1, 1, 0, 16'h8000);   // level 15: pulse, not above PIL
        step("R7",  1, 1, 1, 3, 14);         // PIL=14: irq
        step("R8",  1, 1, 1, 2, 16'h8000);   // level falls: no pulse
        step("R3",  1, 1, 1, 1, 16'h4001);   // level 14 rises
        step("R7",  1, 1, 1, 3, 13);
        step("R6",  0, 1, 1, 6, 16'hFFFF);   // idle: no fault
        step("R6",  0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule